// File: doc/BRIEF.md
# Dual Event Counter Unit

This block is a compact performance-monitoring unit. It holds two 32-bit event counters packed into one 64-bit counter register and governed by one 64-bit control register. Each counter picks one line from a bus of single-cycle event strobes through its own select field. It advances by one on every cycle where that line is high and the enable bit for the current privilege context is set. The three context enables (user, supervisor, hypervisor) are shared by both counters, so the counters cannot be stopped one at a time.

Software presets a counter to the two's complement of a sampling period. The counter then wraps from all-ones to zero after exactly that many events. Each wrap sets a sticky flag, and the flags, gated by an interrupt enable, drive the interrupt line. Any write to the control register clears both flags, so the same write that re-arms the unit also acknowledges the interrupt. The register port is a plain one-cycle write strobe with an address bit and combinational read data.

Top module: `dual_evt_ctr_unit`

## Requirements
- R1: After reset, both registers read zero and `irq` is low.
- R2: Counter i increments by one on a cycle only when strobe `evt_strobe[sel_i]` is high and the enable bit for the current `ctx` is set. `ctx` encoding: 0 user (enable bit 0), 1 supervisor (bit 1), 2 hypervisor (bit 2). A `ctx` value of 3 never counts.
- R3: While all three context enable bits are clear, neither counter changes.
- R4: Counter register (`reg_addr`=1): counter 0 is bits 63:32 and counter 1 is bits 31:0. `reg_be[1]` writes bits 63:32 and `reg_be[0]` writes bits 31:0. A half that is not enabled keeps its value.
- R5: An increment from 0xFFFFFFFF wraps the counter to 0 and sets its sticky flag (control bit 24 for counter 0, bit 25 for counter 1) on the same clock edge. The flag stays set until a control write.
- R6: `irq` equals the interrupt enable (control bit 3) ANDed with the OR of both flags, and it changes on the same edge as the flags.
- R7: Any control write clears both flags, even one that rewrites the same value. An overflow in the same cycle as a control write leaves no flag.
- R8: A select value of `NUM_EVT` or above picks a constant zero, so that counter never advances.
- R9: When a counter write and an increment hit the same counter in one cycle, the written value is stored and the increment is lost.
- R10: A counter preset to 2^32 - N sets its flag on the N-th counted event and not before.
- R11: Control register layout: bits 2:0 are the context enables, bit 3 is the interrupt enable, bits 11:8 are select 0 and bits 19:16 are select 1. Flag bits 25:24 are read-only, and all other bits read zero. Counting in the cycle of a control write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | NUM_EVT | Event strobes, one per event source |
| ctx | input | 2 | Current privilege context |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the counter register |
| reg_be | input | 2 | Half enables for counter writes (bit 1 = upper half) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the register chosen by `reg_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
A counter that misses or doubles one increment shows up in the counter read one cycle later, and its flag then rises one event early or late, which also moves `irq`. A flag that is not sticky, or that survives a control write, appears on `irq` and in bits 25:24 on the edge right after the mistake. A select or gate that is wrongly decoded makes a counter drift from its expected value within a few random cycles. The bench reads one register every cycle, alternating at random between the two, so any divergence appears within a cycle or two.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int CTR_W      = 32;
  localparam int NUM_CTR    = 2;
  localparam int REG_W      = NUM_CTR * CTR_W;
  localparam int SEL_W      = 4;
  localparam int CTX_W      = 2;
  localparam int N_CTX      = 3;
  localparam int EN_LSB     = 0;
  localparam int IRQ_EN_BIT = 3;
  localparam int SEL_LSB    = 8;
  localparam int SEL_STRIDE = 8;
  localparam int FLAG_LSB   = 24;

  typedef enum logic [CTX_W-1:0] {
    CTX_USER = 2'd0,
    CTX_SUPV = 2'd1,
    CTX_HYPV = 2'd2,
    CTX_RSVD = 2'd3
  } ctx_e;

  typedef struct packed {
    logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    logic                          irq_en;
    logic [N_CTX-1:0]              ctx_en;
  } ctl_t;

  // Counting allowed in this context?
  function automatic logic ctx_gate(logic [N_CTX-1:0] en, logic [CTX_W-1:0] cx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_CTX; i++)
      if (cx == CTX_W'(i) && en[i]) r = 1'b1;
    return r;
  endfunction

  // Counter i lives in register half (NUM_CTR-1-i): counter 0 on top.
  function automatic int half_of(int i);
    return NUM_CTR - 1 - i;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctl(ctl_t c, logic [NUM_CTR-1:0] flg);
    logic [REG_W-1:0] r;
    r = '0;
    r[EN_LSB +: N_CTX] = c.ctx_en;
    r[IRQ_EN_BIT]      = c.irq_en;
    for (int i = 0; i < NUM_CTR; i++)
      r[SEL_LSB + i*SEL_STRIDE +: SEL_W] = c.sel[i];
    r[FLAG_LSB +: NUM_CTR] = flg;
    return r;
  endfunction

  function automatic ctl_t unpack_ctl(logic [REG_W-1:0] d);
    ctl_t c;
    c.ctx_en = d[EN_LSB +: N_CTX];
    c.irq_en = d[IRQ_EN_BIT];
    for (int i = 0; i < NUM_CTR; i++)
      c.sel[i] = d[SEL_LSB + i*SEL_STRIDE +: SEL_W];
    return c;
  endfunction

  function automatic logic at_top(logic [CTR_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/evt_mux.sv
module evt_mux #(
  parameter int NUM_EVT = 10,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_EVT-1:0] strobes,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  localparam int PAD = 1 << SEL_W;

  logic [PAD-1:0] padded;

  for (genvar j = 0; j < PAD; j++) begin : g_pad
    if (j < NUM_EVT) begin : g_live
      assign padded[j] = strobes[j];
    end else begin : g_zero
      assign padded[j] = 1'b0;
    end
  end

  assign hit = padded[sel];

  // R8: out-of-range selects never produce a hit
  always_comb begin
    if (32'(sel) >= NUM_EVT)
      a_r8_oob_silent: assert (!hit);
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [CTR_W-1:0] wdata,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap_evt
);
  import dcu_pkg::*;

  assign wrap_evt = inc && !wr && at_top(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (inc) cnt <= cnt + 1'b1;
  end

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr) |=> cnt == CTR_W'($past(cnt) + 1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(cnt));
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == '0);
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg
  import dcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_CTR-1:0] wrap,
  output ctl_t               ctl,
  output logic [NUM_CTR-1:0] flags,
  output logic               irq
);
  logic unused_bits;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl   <= '0;
      flags <= '0;
    end else if (wr) begin
      ctl   <= unpack_ctl(wdata);
      flags <= '0;
    end else begin
      flags <= flags | wrap;
    end
  end

  assign irq = ctl.irq_en && (|flags);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> flags == '0);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (flags & $past(flags)) == $past(flags));
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && |wrap) |=> (flags & $past(wrap)) == $past(wrap));
endmodule

// File: rtl/dual_evt_ctr_unit.sv
module dual_evt_ctr_unit #(
  parameter int NUM_EVT = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EVT-1:0]        evt_strobe,
  input  logic [1:0]                ctx,
  input  logic                      reg_wr,
  input  logic                      reg_addr,
  input  logic [1:0]                reg_be,
  input  logic [63:0]               reg_wdata,
  output logic [63:0]               reg_rdata,
  output logic                      irq
);
  import dcu_pkg::*;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_CTR = 1'b1;

  ctl_t               ctl;
  logic [NUM_CTR-1:0] flags;
  logic [NUM_CTR-1:0] hit, inc, wrap, ctr_wr;
  logic [REG_W-1:0]   ctr_bus;
  logic               count_ok;
  logic               ctl_wr;

  assign count_ok = ctx_gate(ctl.ctx_en, ctx);
  assign ctl_wr   = reg_wr && (reg_addr == ADDR_CTL);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int H = half_of(i);
    logic [CTR_W-1:0] cnt;

    evt_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
      .strobes (evt_strobe),
      .sel     (ctl.sel[i]),
      .hit     (hit[i])
    );

    assign inc[i]    = hit[i] && count_ok;
    assign ctr_wr[i] = reg_wr && (reg_addr == ADDR_CTR) && reg_be[H];

    ctr_slice #(.CTR_W(CTR_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc[i]),
      .wr       (ctr_wr[i]),
      .wdata    (reg_wdata[H*CTR_W +: CTR_W]),
      .cnt      (cnt),
      .wrap_evt (wrap[i])
    );

    assign ctr_bus[H*CTR_W +: CTR_W] = cnt;
  end

  ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (reg_wdata),
    .wrap  (wrap),
    .ctl   (ctl),
    .flags (flags),
    .irq   (irq)
  );

  assign reg_rdata = (reg_addr == ADDR_CTR) ? ctr_bus : pack_ctl(ctl, flags);

  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ctx_en == '0) |-> (inc == '0));
  a_r2_rsvd_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx == CTX_RSVD) |-> (inc == '0));
  a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !irq);
  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && ctl.irq_en && |wrap) |=> irq);
endmodule

// File: tb/sim_dual_evt_ctr_unit.sv
module sim_dual_evt_ctr_unit;
  localparam int NEVT = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NEVT-1:0] evt_strobe;
  logic [1:0]      ctx;
  logic            reg_wr, reg_addr;
  logic [1:0]      reg_be;
  logic [63:0]     reg_wdata, reg_rdata;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit [31:0] m_cnt [2];
  bit [2:0]  m_en;
  bit        m_ie;
  bit [3:0]  m_sel [2];
  bit [1:0]  m_flag;

  always #4 clk = ~clk;

  dual_evt_ctr_unit #(.NUM_EVT(NEVT)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .ctx(ctx),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic bit [63:0] cw(bit [2:0] en, bit ie, bit [3:0] s0, bit [3:0] s1);
    return 64'(en) | (64'(ie) << 3) | (64'(s0) << 8) | (64'(s1) << 16);
  endfunction

  function automatic bit [63:0] exp_ctl();
    return cw(m_en, m_ie, m_sel[0], m_sel[1]) | (64'(m_flag) << 24);
  endfunction

  function automatic bit exp_irq();
    return m_ie && (m_flag != 2'b00);
  endfunction

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model(bit wr, bit addr, bit [1:0] be, bit [63:0] wd,
                       bit [NEVT-1:0] stb, bit [1:0] cx);
    bit ok;
    bit [1:0] wraps;
    ok = (cx != 2'd3) && m_en[cx];
    wraps = 2'b00;
    for (int i = 0; i < 2; i++) begin
      int h;
      bit hitv;
      h = 1 - i;
      hitv = (int'(m_sel[i]) < NEVT) && stb[m_sel[i]];
      if (wr && addr && be[h]) m_cnt[i] = wd[h*32 +: 32];
      else if (ok && hitv) begin
        wraps[i] = (m_cnt[i] == 32'hFFFF_FFFF);
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (wr && !addr) begin
      m_en = wd[2:0]; m_ie = wd[3]; m_sel[0] = wd[11:8]; m_sel[1] = wd[19:16];
      m_flag = 2'b00;
    end else m_flag = m_flag | wraps;
  endtask

  task automatic apply(string tag, bit wr, bit addr, bit [1:0] be, bit [63:0] wd,
                       bit [NEVT-1:0] stb, bit [1:0] cx);
    reg_wr = wr; reg_addr = addr; reg_be = be; reg_wdata = wd;
    evt_strobe = stb; ctx = cx;
    @(posedge clk);
    model(wr, addr, be, wd, stb, cx);
    @(negedge clk);
    check(tag, "rdata", reg_rdata, addr ? {m_cnt[0], m_cnt[1]} : exp_ctl());
    check(tag, "irq", 64'(irq), 64'(exp_irq()));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_be = 0; reg_wdata = 0;
    evt_strobe = '0; ctx = 0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_en = 0; m_ie = 0; m_sel[0] = 0; m_sel[1] = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    reg_addr = 0; #1;
    check("R1", "ctl", reg_rdata, 64'h0);
    check("R1", "irq", 64'(irq), 64'h0);
    reg_addr = 1; #1;
    check("R1", "ctr", reg_rdata, 64'h0);
    apply("R1", 0, 1, 2'b00, 0, '1, 2'd0);

    // R3: no enables, strobes everywhere
    apply("R3", 1, 0, 2'b00, cw(3'b000, 1, 4'd1, 4'd2), '0, 2'd0);
    for (int k = 0; k < 4; k++) apply("R3", 0, 1, 2'b00, 0, '1, 2'(k));

    // R11: all-ones write, only defined bits stored, flags not set
    apply("R11", 1, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, '0, 2'd0);
    apply("R11", 0, 0, 2'b00, 0, '0, 2'd0);

    // R2: user only; counts in ctx 0, not 1 or 3
    apply("R2", 1, 0, 2'b00, cw(3'b001, 1, 4'd0, 4'd1), '0, 2'd0);
    apply("R2", 0, 1, 2'b00, 0, 10'b0000000011, 2'd0);
    apply("R2", 0, 1, 2'b00, 0, 10'b0000000001, 2'd0);
    apply("R2", 0, 1, 2'b00, 0, 10'b0000000011, 2'd1);
    apply("R2", 0, 1, 2'b00, 0, 10'b0000000011, 2'd3);
    apply("R11", 1, 0, 2'b00, cw(3'b110, 1, 4'd0, 4'd1), '1, 2'd0);
    apply("R2", 0, 1, 2'b00, 0, 10'b0000000010, 2'd2);

    // R4: half writes
    apply("R4", 1, 1, 2'b10, {32'hA5A5_A5A5, 32'h1234_5678}, '0, 2'd0);
    apply("R4", 1, 1, 2'b01, {32'h0BAD_F00D, 32'h0000_1000}, '0, 2'd0);
    apply("R4", 0, 1, 2'b00, 0, '0, 2'd0);

    // R10/R5/R6: preset counter 0 to -5, count 5 events
    apply("R10", 1, 0, 2'b00, cw(3'b001, 1, 4'd0, 4'd1), '0, 2'd0);
    apply("R10", 1, 1, 2'b10, {32'hFFFF_FFFB, 32'h0}, '0, 2'd0);
    for (int k = 0; k < 5; k++) apply("R10", 0, 0, 2'b00, 0, 10'b0000000001, 2'd0);
    apply("R6", 0, 1, 2'b00, 0, '0, 2'd0);
    for (int k = 0; k < 3; k++) apply("R5", 0, 0, 2'b00, 0, 10'b0000000001, 2'd0);

    // R7: same-value rewrite clears; overflow in write cycle dropped
    apply("R7", 1, 0, 2'b00, cw(3'b001, 1, 4'd0, 4'd1), '0, 2'd0);
    apply("R7", 1, 1, 2'b01, {32'h0, 32'hFFFF_FFFF}, '0, 2'd0);
    apply("R7", 1, 0, 2'b00, cw(3'b001, 1, 4'd0, 4'd1), 10'b0000000010, 2'd0);
    apply("R7", 0, 1, 2'b00, 0, '0, 2'd0);
    apply("R6", 1, 0, 2'b00, cw(3'b001, 0, 4'd0, 4'd0), '0, 2'd0);
    apply("R6", 1, 1, 2'b11, {32'hFFFF_FFFF, 32'hFFFF_FFFF}, '0, 2'd0);
    apply("R6", 0, 0, 2'b00, 0, 10'b0000000001, 2'd0);

    // R8: out-of-range select
    apply("R8", 1, 0, 2'b00, cw(3'b111, 1, 4'd10, 4'd15), '0, 2'd0);
    for (int k = 0; k < 3; k++) apply("R8", 0, 1, 2'b00, 0, '1, 2'(k));

    // R9: write beats increment
    apply("R9", 1, 0, 2'b00, cw(3'b111, 1, 4'd9, 4'd9), '0, 2'd0);
    apply("R9", 1, 1, 2'b11, {32'h0000_0100, 32'h0000_0200}, 10'b1000000000, 2'd1);
    apply("R9", 1, 1, 2'b10, {32'h0000_0777, 32'h0}, 10'b1000000000, 2'd1);

    // constrained random
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      bit wr, addr;
      bit [1:0] be;
      bit [63:0] wd;
      wr = ($urandom_range(0, 7) == 0);
      addr = $urandom_range(0, 1);
      be = 2'($urandom_range(0, 3));
      if (addr) wd = {28'hFFF_FFFF, 4'($urandom), 28'hFFF_FFFF, 4'($urandom)};
      else wd = {$urandom, $urandom} | 64'h1;
      apply("R2 R5 R6 random", wr, wr ? addr : $urandom_range(0, 1), be, wd,
            NEVT'($urandom), 2'($urandom));
    end

    reg_wr = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule